// File: doc/BRIEF.md
# Next-PC and Branch/Jump Unit

This block owns the program counter of a simple 32-bit in-order core. In each cycle it looks at the instruction word being executed and at the two register operands already read for it. From these it picks the address of the next instruction: the following word, a PC-relative branch target, a region-local absolute jump target or a register-held address. On a call it also asks the register file to save the return address.

The fetch stage uses `pc` as the instruction address. The decode and register-read logic feeds back the instruction word and the two operand values in the same cycle. A `stall` input freezes the counter whenever the surrounding pipeline cannot advance. The link request (`link_we`, `link_idx`, `link_val`) is combinational from the current instruction. The register file consumes it at the same clock edge that updates the PC.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high `rst` loads `pc` with 0x00000000 at the next rising edge. `rst` takes priority over `stall`, and `link_we` is low while `rst` is high.
- R2: When the instruction is not a control transfer, `pc` advances by 4 at each unstalled edge. This covers unlisted opcodes and opcode 0x00 with any function code (bits 5..0) other than 0x08.
- R3: Opcode 0x04 (branch-if-equal) with `rs_val == rt_val` loads `pc + 4 + (sign-extended bits 15..0 shifted left by 2)`.
- R4: Opcode 0x05 (branch-if-not-equal) takes the same target when `rs_val != rt_val`. A branch whose condition fails falls through to `pc + 4`.
- R5: The 16-bit branch offset is two's-complement, so an offset of 0xFFFF branches back to the branch itself.
- R6: Opcode 0x02 (jump) loads `{upper 4 bits, bits 25..0 of the instruction, 2'b00}`.
- R7: The upper 4 bits of a jump target come from `pc + 4`, not from `pc`. A jump in the last word of a 256 MB region therefore lands in the next region.
- R8: Opcode 0x03 (jump-and-link) jumps like R6. In the same cycle it drives `link_we = 1`, `link_idx = 31` and `link_val = pc + 4`.
- R9: Opcode 0x00 with function code 0x08 (jump-register) loads `pc` with `rs_val`.
- R10: While `stall` is high, `pc` holds its value and `link_we` is low, whatever the instruction.
- R11: `link_we` is low for every instruction other than jump-and-link.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold the PC and suppress the link request |
| instr | input | 32 | Instruction word currently executing |
| rs_val | input | 32 | Value read from the register named in bits 25..21 |
| rt_val | input | 32 | Value read from the register named in bits 20..16 |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Request to write the return address |
| link_idx | output | 5 | Register index for the return address |
| link_val | output | 32 | Return address (`pc + 4`) |

## Verification
The bench goes after negative branch offsets, including a branch back to itself. A design that zero-extends the offset would jump forward by almost 256 KB instead. It jumps from the last word of a 256 MB region. A design that takes the upper bits from the current PC rather than PC+4 would wrap back to the start of the old region. It also sends opcode 0x00 with a function code other than jump-register, a stalled jump-and-link and a reset that coincides with a jump. A decoder that ignores the function field would redirect ordinary arithmetic. A design that does not gate the link request on stall would write the return register twice.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
   localparam int INSTR_W = 32;
   localparam int OPC_W   = 6;
   localparam int REG_W   = 5;
   localparam int FUNCT_W = 6;
   localparam int IMM_W   = 16;
   localparam int JFLD_W  = 26;
   localparam int OPC_LSB = INSTR_W - OPC_W;

   localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'h00;
   localparam logic [OPC_W-1:0]   OPC_JUMP    = 6'h02;
   localparam logic [OPC_W-1:0]   OPC_JLINK   = 6'h03;
   localparam logic [OPC_W-1:0]   OPC_BREQ    = 6'h04;
   localparam logic [OPC_W-1:0]   OPC_BRNE    = 6'h05;
   localparam logic [FUNCT_W-1:0] FN_JREG     = 6'h08;

   typedef enum logic [2:0] {
      FLOW_SEQ,
      FLOW_BREQ,
      FLOW_BRNE,
      FLOW_JUMP,
      FLOW_JLINK,
      FLOW_JREG
   } flow_e;

   typedef struct packed {
      flow_e              flow;
      logic [IMM_W-1:0]   imm;
      logic [JFLD_W-1:0]  jfield;
   } ctl_t;
endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
   import pcseq_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output ctl_t               ctl
);
   logic [OPC_W-1:0]   opcode;
   logic [FUNCT_W-1:0] funct;

   assign opcode = instr[INSTR_W-1 -: OPC_W];
   assign funct  = instr[FUNCT_W-1:0];

   always_comb begin
      ctl.imm    = instr[IMM_W-1:0];
      ctl.jfield = instr[JFLD_W-1:0];
      case (opcode)
         OPC_BREQ:    ctl.flow = FLOW_BREQ;
         OPC_BRNE:    ctl.flow = FLOW_BRNE;
         OPC_JUMP:    ctl.flow = FLOW_JUMP;
         OPC_JLINK:   ctl.flow = FLOW_JLINK;
         OPC_SPECIAL: ctl.flow = (funct == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
         default:     ctl.flow = FLOW_SEQ;
      endcase
   end
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
   import pcseq_pkg::*;
#(
   parameter int ADDR_W            = 32,
   parameter bit JUMP_HI_FROM_NEXT = 1'b1
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [IMM_W-1:0]  imm,
   input  logic [JFLD_W-1:0] jfield,
   output logic [ADDR_W-1:0] pc_plus4,
   output logic [ADDR_W-1:0] br_tgt,
   output logic [ADDR_W-1:0] jmp_tgt
);
   localparam int JT_W     = JFLD_W + 2;
   localparam int REGION_W = ADDR_W - JT_W;
   localparam int SEXT_W   = ADDR_W - IMM_W - 2;

   if (REGION_W < 1) begin : g_bad_width
      $error("pcseq_target: ADDR_W must exceed the jump field span");
   end

   logic [ADDR_W-1:0]   offset;
   logic [REGION_W-1:0] region_hi;

   assign pc_plus4 = pc + ADDR_W'(4);
   assign offset   = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
   assign br_tgt   = pc_plus4 + offset;

   if (JUMP_HI_FROM_NEXT) begin : g_hi_next
      assign region_hi = pc_plus4[ADDR_W-1 -: REGION_W];
   end else begin : g_hi_cur
      assign region_hi = pc[ADDR_W-1 -: REGION_W];
   end

   assign jmp_tgt = {region_hi, jfield, 2'b00};
endmodule

// File: rtl/pcseq_cond.sv
module pcseq_cond
   import pcseq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  flow_e             flow,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              take
);
   logic same;

   assign same = (opa == opb);

   always_comb begin
      case (flow)
         FLOW_BREQ: take = same;
         FLOW_BRNE: take = !same;
         default:   take = 1'b0;
      endcase
   end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
   import pcseq_pkg::*;
#(
   parameter int                ADDR_W            = 32,
   parameter int                DATA_W            = 32,
   parameter logic [ADDR_W-1:0] RESET_PC          = '0,
   parameter int                LINK_REG          = 31,
   parameter bit                JUMP_HI_FROM_NEXT = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               stall,
   input  logic [31:0]        instr,
   input  logic [DATA_W-1:0]  rs_val,
   input  logic [DATA_W-1:0]  rt_val,
   output logic [ADDR_W-1:0]  pc,
   output logic               link_we,
   output logic [REG_W-1:0]   link_idx,
   output logic [ADDR_W-1:0]  link_val
);
   if (DATA_W != ADDR_W) begin : g_bad_data
      $error("pc_sequencer: register width must equal address width");
   end
   if (LINK_REG < 0 || LINK_REG >= (1 << REG_W)) begin : g_bad_link
      $error("pc_sequencer: LINK_REG out of register index range");
   end
   if (INSTR_W != 32) begin : g_bad_instr
      $error("pc_sequencer: instruction word must be 32 bits");
   end

   ctl_t              ctl;
   logic              br_take;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_nxt;
   logic [ADDR_W-1:0] pc_plus4;
   logic [ADDR_W-1:0] br_tgt;
   logic [ADDR_W-1:0] jmp_tgt;

   pcseq_decode u_dec (
      .instr (instr),
      .ctl   (ctl)
   );

   pcseq_target #(
      .ADDR_W            (ADDR_W),
      .JUMP_HI_FROM_NEXT (JUMP_HI_FROM_NEXT)
   ) u_tgt (
      .pc       (pc_q),
      .imm      (ctl.imm),
      .jfield   (ctl.jfield),
      .pc_plus4 (pc_plus4),
      .br_tgt   (br_tgt),
      .jmp_tgt  (jmp_tgt)
   );

   pcseq_cond #(
      .DATA_W (DATA_W)
   ) u_cond (
      .flow (ctl.flow),
      .opa  (rs_val),
      .opb  (rt_val),
      .take (br_take)
   );

   always_comb begin
      case (ctl.flow)
         FLOW_JUMP, FLOW_JLINK: pc_nxt = jmp_tgt;
         FLOW_JREG:             pc_nxt = rs_val;
         FLOW_BREQ, FLOW_BRNE:  pc_nxt = br_take ? br_tgt : pc_plus4;
         default:               pc_nxt = pc_plus4;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= RESET_PC;
      end else if (!stall) begin
         pc_q <= pc_nxt;
      end
   end

   assign pc       = pc_q;
   assign link_we  = (ctl.flow == FLOW_JLINK) && !stall && !rst;
   assign link_idx = REG_W'(LINK_REG);
   assign link_val = pc_plus4;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
   parameter int                ADDR_W   = 32,
   parameter int                DATA_W   = 32,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   parameter int                LINK_REG = 31
) (
   input logic              clk,
   input logic              rst,
   input logic              stall,
   input logic [31:0]       instr,
   input logic [DATA_W-1:0] rs_val,
   input logic [DATA_W-1:0] rt_val,
   input logic [ADDR_W-1:0] pc,
   input logic              link_we,
   input logic [4:0]        link_idx,
   input logic [ADDR_W-1:0] link_val
);
   logic past_valid = 1'b0;
   always_ff @(posedge clk) past_valid <= 1'b1;

   logic [5:0]        op;
   logic              is_jr;
   logic              is_seq;
   logic [ADDR_W-1:0] boff;

   assign op     = instr[31:26];
   assign is_jr  = (op == 6'h00) && (instr[5:0] == 6'h08);
   assign is_seq = !is_jr && (op != 6'h02) && (op != 6'h03) &&
                   (op != 6'h04) && (op != 6'h05);
   assign boff   = {{(ADDR_W-18){instr[15]}}, instr[15:0], 2'b00};

   // R1
   a_r1_reset_pc: assert property (@(posedge clk) disable iff (!past_valid)
      $past(rst) |-> pc == RESET_PC);

   a_r1_no_link_in_reset: assert property (@(posedge clk)
      rst |-> !link_we);

   a_r2_sequential: assert property (@(posedge clk) disable iff (rst || !past_valid)
      (!stall && is_seq) |=> pc == $past(pc) + ADDR_W'(4));

   a_r3_beq_taken: assert property (@(posedge clk) disable iff (rst || !past_valid)
      (!stall && op == 6'h04 && rs_val == rt_val) |=> pc == $past(pc) + ADDR_W'(4) + $past(boff));

   a_r4_bne_fall: assert property (@(posedge clk) disable iff (rst || !past_valid)
      (!stall && op == 6'h05 && rs_val == rt_val) |=> pc == $past(pc) + ADDR_W'(4));

   a_r6_jump_low: assert property (@(posedge clk) disable iff (rst || !past_valid)
      (!stall && (op == 6'h02 || op == 6'h03)) |=> pc[27:0] == {$past(instr[25:0]), 2'b00});

   a_r8_link: assert property (@(posedge clk) disable iff (rst)
      (!stall && op == 6'h03) |-> (link_we && link_idx == 5'(LINK_REG) && link_val == pc + ADDR_W'(4)));

   a_r9_jr: assert property (@(posedge clk) disable iff (rst || !past_valid)
      (!stall && is_jr) |=> pc == $past(rs_val));

   a_r10_hold: assert property (@(posedge clk) disable iff (rst || !past_valid)
      stall |=> $stable(pc));

   a_r10_no_link: assert property (@(posedge clk)
      stall |-> !link_we);

   a_r11_link_only_jal: assert property (@(posedge clk)
      (op != 6'h03) |-> !link_we);
endmodule

bind pc_sequencer pc_sequencer_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .RESET_PC (RESET_PC),
   .LINK_REG (LINK_REG)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .stall    (stall),
   .instr    (instr),
   .rs_val   (rs_val),
   .rt_val   (rt_val),
   .pc       (pc),
   .link_we  (link_we),
   .link_idx (link_idx),
   .link_val (link_val)
);

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stall = 1'b0;
   logic [31:0] instr = 32'h0;
   logic [31:0] rs_val = 32'h0;
   logic [31:0] rt_val = 32'h0;
   logic [31:0] pc;
   logic        link_we;
   logic [4:0]  link_idx;
   logic [31:0] link_val;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pc_sequencer uut (
      .clk      (clk),
      .rst      (rst),
      .stall    (stall),
      .instr    (instr),
      .rs_val   (rs_val),
      .rt_val   (rt_val),
      .pc       (pc),
      .link_we  (link_we),
      .link_idx (link_idx),
      .link_val (link_val)
   );

   function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [15:0] imm);
      return {op, 5'd1, 5'd2, imm};
   endfunction

   function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] fld);
      return {op, fld};
   endfunction

   function automatic logic [31:0] mk_r(input logic [5:0] fn);
      return {6'h00, 5'd3, 5'd4, 5'd5, 5'd0, fn};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at the falling edge, let the rising edge update pc, sample 1 ns later
   task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic stl, input logic rs);
      @(negedge clk);
      instr = ins; rs_val = a; rt_val = b; stall = stl; rst = rs;
      #1;
   endtask

   task automatic edge_wait();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      step(mk_r(6'h20), 0, 0, 1'b0, 1'b1);
      edge_wait();
      chk("R1 reset pc", pc, 32'h0);
   endtask

   task automatic t_sequential();
      step(mk_r(6'h20), 5, 5, 1'b0, 1'b0);
      chk("R11 link_we on alu op", {31'h0, link_we}, 32'h0);
      edge_wait();
      chk("R2 alu op advances", pc, 32'h4);
      step(mk_i(6'h23, 16'h0010), 0, 0, 1'b0, 1'b0);
      edge_wait();
      chk("R2 load op advances", pc, 32'h8);
      step(mk_i(6'h3F, 16'hFFFF), 0, 0, 1'b0, 1'b0);
      edge_wait();
      chk("R2 unlisted opcode advances", pc, 32'hC);
      step(mk_r(6'h09), 32'h5000, 0, 1'b0, 1'b0);
      edge_wait();
      chk("R2 special op non-jr funct", pc, 32'h10);
   endtask

   task automatic t_branches();
      step(mk_i(6'h04, 16'h0003), 7, 7, 1'b0, 1'b0);
      edge_wait();
      chk("R3 beq taken", pc, 32'h20);
      step(mk_i(6'h04, 16'h0003), 7, 8, 1'b0, 1'b0);
      edge_wait();
      chk("R4 beq not taken", pc, 32'h24);
      step(mk_i(6'h05, 16'h0010), 1, 2, 1'b0, 1'b0);
      edge_wait();
      chk("R4 bne taken", pc, 32'h68);
      step(mk_i(6'h05, 16'h0010), 9, 9, 1'b0, 1'b0);
      edge_wait();
      chk("R4 bne not taken", pc, 32'h6C);
   endtask

   task automatic t_negative();
      step(mk_i(6'h04, 16'hFFFE), 3, 3, 1'b0, 1'b0);
      edge_wait();
      chk("R5 beq back two words", pc, 32'h68);
      step(mk_i(6'h05, 16'hFFFF), 3, 4, 1'b0, 1'b0);
      edge_wait();
      chk("R5 bne to itself", pc, 32'h68);
   endtask

   task automatic t_jumps();
      step(mk_r(6'h08), 32'h0FFF_FFFC, 32'h1234, 1'b0, 1'b0);
      edge_wait();
      chk("R9 jr loads rs", pc, 32'h0FFF_FFFC);
      step(mk_j(6'h02, 26'h000_0040), 0, 0, 1'b0, 1'b0);
      chk("R11 link_we on j", {31'h0, link_we}, 32'h0);
      edge_wait();
      chk("R7 j region from pc+4", pc, 32'h1000_0100);
      step(mk_j(6'h02, 26'h3FF_FFFF), 0, 0, 1'b0, 1'b0);
      edge_wait();
      chk("R6 j full field", pc, 32'h1FFF_FFFC);
      step(mk_j(6'h03, 26'h000_0010), 0, 0, 1'b0, 1'b0);
      chk("R8 jal link_we", {31'h0, link_we}, 32'h1);
      chk("R8 jal link_idx", {27'h0, link_idx}, 32'd31);
      chk("R8 jal link_val", link_val, 32'h2000_0000);
      edge_wait();
      chk("R8 R7 jal target", pc, 32'h2000_0040);
   endtask

   task automatic t_stall();
      step(mk_j(6'h03, 26'h000_0100), 0, 0, 1'b1, 1'b0);
      chk("R10 no link when stalled", {31'h0, link_we}, 32'h0);
      edge_wait();
      chk("R10 pc held on jal", pc, 32'h2000_0040);
      step(mk_i(6'h04, 16'h0005), 6, 6, 1'b1, 1'b0);
      edge_wait();
      chk("R10 pc held on beq", pc, 32'h2000_0040);
      step(mk_r(6'h20), 0, 0, 1'b0, 1'b0);
      edge_wait();
      chk("R2 resume after stall", pc, 32'h2000_0044);
      step(mk_r(6'h08), 32'h0000_1000, 0, 1'b0, 1'b0);
      chk("R11 link_we on jr", {31'h0, link_we}, 32'h0);
      edge_wait();
      chk("R9 jr second target", pc, 32'h0000_1000);
   endtask

   task automatic t_reset_mid();
      step(mk_j(6'h03, 26'h000_0200), 0, 0, 1'b1, 1'b1);
      chk("R1 no link in reset", {31'h0, link_we}, 32'h0);
      edge_wait();
      chk("R1 reset beats stall and jal", pc, 32'h0);
      step(mk_r(6'h20), 0, 0, 1'b0, 1'b0);
      edge_wait();
      chk("R2 first step after reset", pc, 32'h4);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      t_reset();
      t_sequential();
      t_branches();
      t_negative();
      t_jumps();
      t_stall();
      t_reset_mid();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule